// File: doc/BRIEF.md
# Cascadable Delay-Select Latch Controller

This block holds the select code of one or more stages of a programmable delay line and works out the delay that code asks for. Each stage receives an eight-bit code. The low seven bits are a delay address. Each step of the address adds a quarter of a gate delay. The top bit asks for the next stage of the chain to take part. The stage stores the code in its latches, unless one of its two override inputs is active. A force-to-minimum override clears every latch. A force-to-maximum override writes a fixed pattern: bits 0 and 1 clear, bits 2 to 7 set. Under that pattern the stage adds one more gate, so the stage delay climbs from 31.75 gates to 32 and the sequence stays monotonic. Each stage reports its delay as a count of quarter gates: the address value, 0 under the minimum override, or 128 under the maximum override.

The top module `dly_chain` joins `STAGES` stages. All stages share one seven-bit address bus. Each stage except the last receives one cascade line of its own, so every added stage costs one more address line. The inverted cascade output of a stage drives the minimum override of the stage after it. The stage's own latched cascade bit drives its own maximum override. A stage whose cascade bit is low therefore keeps its successor at zero. A stage whose cascade bit is high sets itself to 32 gates and hands the address to its successor. The wrapper adds the stage counts into one total.

Each stage decodes a mode every cycle, in priority order: `MODE_FORCE_MIN` when its minimum override is high; otherwise `MODE_FORCE_MAX` when its maximum override is high; otherwise `MODE_HOLD` when the latch-hold input is high; otherwise `MODE_TRACK`. Every mode can move directly to any other. A transition happens as soon as the inputs that select the new mode change. In `MODE_TRACK` the latches load the code at each rising clock edge. In `MODE_HOLD` they keep their value. The two forcing modes act on the outputs at once and write their pattern into the latches at the next edge.

Top module: `dly_chain`

## Requirements
- R1: After reset every stage select is 0x00, every stage count is 0 and the total is 0.
- R2: While latch_hold is low and no override is active, a stage loads its eight-bit code at each rising edge. Its select output equals the loaded code, and its count equals the low seven bits.
- R3: While latch_hold is high and no override is active, changes on the address bus and on the cascade lines leave the select outputs and the total unchanged.
- R4: While ext_min is high, the select of stage 0 is 0x00 and its count is 0, in the same cycle and whatever the address bus holds.
- R5: While ext_max is high and ext_min is low, the select of stage 0 is 0xFC (bits 0 and 1 clear, bits 2 to 7 set) and its count is 128.
- R6: When ext_min and ext_max are both high, the minimum override wins: stage 0 selects 0x00 and the total is 0.
- R7: For each stage, the cascade output equals bit 7 of its select, and the inverted cascade output is always the complement of the cascade output.
- R8: When a stage's cascade output is low, the next stage selects 0x00. When it is high, the stage counts 128 and the next stage follows the shared address.
- R9: The total equals the sum of the stage counts. Take the combined code k = 128·L + a, where the first L cascade lines are high and a is the address. With the latches open, the total settles to k, so the total never drops as k steps up across a stage boundary.
- R10: When an override is released while latch_hold is high, the stage keeps the pattern that the override wrote. After the minimum override the select is 0x00. After the maximum override the select is 0x7C with count 124, and the cascade bit is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select latches |
| rst_n | input | 1 | Active-low asynchronous reset |
| latch_hold | input | 1 | High holds the latches; low lets them load at each edge |
| addr | input | ADDR_W | Shared delay address, one quarter gate per step |
| casc_ctl | input | STAGES-1 | Cascade request bit for stages 0 to STAGES-2 |
| ext_min | input | 1 | Force-to-minimum override for stage 0 |
| ext_max | input | 1 | Force-to-maximum override for stage 0 |
| stage_sel | output | STAGES*(ADDR_W+1) | Select code of each stage, stage 0 in the low field |
| stage_dly | output | STAGES*(ADDR_W+1) | Quarter-gate count of each stage |
| casc_vec | output | STAGES | Cascade output of each stage |
| casc_n_vec | output | STAGES | Inverted cascade output of each stage |
| total_dly | output | ADDR_W+1+clog2(STAGES) | Sum of all stage counts |

## Verification
The overrides act through combinational paths only. A forced result is therefore present in the same cycle as the override, and the bench checks it before the next edge that could write the latches. A code change needs one edge to reach the first stage. Each further stage it must release costs one more edge, because a successor sees the new cascade bit only after its predecessor has latched it. The driver therefore waits two edges with STAGES=2 before it queues the expected result. The monitor compares that result five nanoseconds after the last of those edges, well before the driver changes any input again.

// File: rtl/dly_pkg.sv
package dly_pkg;

    typedef enum logic [1:0] {
        MODE_TRACK,
        MODE_HOLD,
        MODE_FORCE_MIN,
        MODE_FORCE_MAX
    } stage_mode_e;

endpackage

// File: rtl/dly_mode_dec.sv
module dly_mode_dec
    import dly_pkg::*;
(
    input  logic        set_min,
    input  logic        set_max,
    input  logic        hold,
    output stage_mode_e mode
);

    // Priority: minimum override, then maximum override, then hold.
    always_comb begin
        unique casez ({set_min, set_max, hold})
            3'b1??:  mode = MODE_FORCE_MIN;
            3'b01?:  mode = MODE_FORCE_MAX;
            3'b001:  mode = MODE_HOLD;
            default: mode = MODE_TRACK;
        endcase
    end

endmodule

// File: rtl/dly_stage.sv
module dly_stage
    import dly_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W:0]   code,
    input  logic              set_min,
    input  logic              set_max,
    output logic [ADDR_W:0]   sel,
    output logic [ADDR_W:0]   dly_cnt,
    output logic              casc,
    output logic              casc_n,
    output logic              casc_req
);

    localparam int CODE_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] MAX_PAT = {{(ADDR_W-2){1'b1}}, 2'b00};
    localparam logic [CODE_W-1:0] MAX_CNT = CODE_W'(1) << ADDR_W;

    stage_mode_e       mode;
    logic [ADDR_W-1:0] addr_q;
    logic              cas_q;

    dly_mode_dec u_dec (
        .set_min (set_min),
        .set_max (set_max),
        .hold    (hold),
        .mode    (mode)
    );

    // State register: latch contents written per decoded mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cas_q  <= 1'b0;
        end else begin
            unique case (mode)
                MODE_TRACK: begin
                    addr_q <= code[ADDR_W-1:0];
                    cas_q  <= code[ADDR_W];
                end
                MODE_HOLD: begin
                    addr_q <= addr_q;
                    cas_q  <= cas_q;
                end
                MODE_FORCE_MIN: begin
                    addr_q <= '0;
                    cas_q  <= 1'b0;
                end
                MODE_FORCE_MAX: begin
                    addr_q <= MAX_PAT;
                    // cascade latch keeps following its input so that
                    // the stage can leave the maximum setting again
                    cas_q  <= hold ? cas_q : code[ADDR_W];
                end
            endcase
        end
    end

    // Outputs: overrides act immediately, otherwise the latch contents.
    always_comb begin
        unique case (mode)
            MODE_FORCE_MIN: begin
                sel     = '0;
                dly_cnt = '0;
            end
            MODE_FORCE_MAX: begin
                sel     = {1'b1, MAX_PAT};
                dly_cnt = MAX_CNT;
            end
            MODE_TRACK, MODE_HOLD: begin
                sel     = {cas_q, addr_q};
                dly_cnt = {1'b0, addr_q};
            end
        endcase
    end

    assign casc     = sel[ADDR_W];
    assign casc_n   = ~sel[ADDR_W];
    assign casc_req = cas_q;

endmodule

// File: rtl/dly_sum.sv
module dly_sum #(
    parameter int W_IN  = 8,
    parameter int N     = 2,
    parameter int W_OUT = 9
) (
    input  logic [N*W_IN-1:0] vec,
    output logic [W_OUT-1:0]  sum
);

    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + W_OUT'(vec[i*W_IN +: W_IN]);
        end
    end

endmodule

// File: rtl/dly_chain.sv
module dly_chain #(
    parameter int ADDR_W = 7,
    parameter int STAGES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               latch_hold,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [STAGES-2:0]                  casc_ctl,
    input  logic                               ext_min,
    input  logic                               ext_max,
    output logic [STAGES*(ADDR_W+1)-1:0]       stage_sel,
    output logic [STAGES*(ADDR_W+1)-1:0]       stage_dly,
    output logic [STAGES-1:0]                  casc_vec,
    output logic [STAGES-1:0]                  casc_n_vec,
    output logic [ADDR_W+$clog2(STAGES):0]     total_dly
);

    localparam int CODE_W = ADDR_W + 1;
    localparam int TOT_W  = ADDR_W + 1 + $clog2(STAGES);

    logic [STAGES-1:0] req;
    logic [STAGES-1:0] min_in;
    logic [STAGES-1:0] max_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [CODE_W-1:0] code_s;

        if (s < STAGES - 1) begin : g_mid
            assign code_s = {casc_ctl[s], addr};
        end else begin : g_last
            assign code_s = {1'b0, addr};
        end

        if (s == 0) begin : g_head
            assign min_in[s] = ext_min;
            assign max_in[s] = ext_max | req[s];
        end else begin : g_tail
            assign min_in[s] = casc_n_vec[s-1];
            assign max_in[s] = req[s];
        end

        dly_stage #(.ADDR_W(ADDR_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (latch_hold),
            .code     (code_s),
            .set_min  (min_in[s]),
            .set_max  (max_in[s]),
            .sel      (stage_sel[s*CODE_W +: CODE_W]),
            .dly_cnt  (stage_dly[s*CODE_W +: CODE_W]),
            .casc     (casc_vec[s]),
            .casc_n   (casc_n_vec[s]),
            .casc_req (req[s])
        );
    end

    dly_sum #(.W_IN(CODE_W), .N(STAGES), .W_OUT(TOT_W)) u_sum (
        .vec (stage_dly),
        .sum (total_dly)
    );

endmodule

// File: rtl/dly_chain_chk.sv
module dly_chain_chk #(
    parameter int ADDR_W = 7,
    parameter int STAGES = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           latch_hold,
    input logic                           ext_min,
    input logic                           ext_max,
    input logic [STAGES*(ADDR_W+1)-1:0]   stage_sel,
    input logic [STAGES*(ADDR_W+1)-1:0]   stage_dly,
    input logic [STAGES-1:0]              casc_vec,
    input logic [STAGES-1:0]              casc_n_vec,
    input logic [ADDR_W+$clog2(STAGES):0] total_dly
);

    localparam int CW = ADDR_W + 1;
    localparam int TW = ADDR_W + 1 + $clog2(STAGES);
    localparam logic [CW-1:0] FULL_PAT = {{(CW-2){1'b1}}, 2'b00};
    localparam logic [CW-1:0] TOP_CNT  = CW'(1) << ADDR_W;

    function automatic logic [TW-1:0] add_counts(input logic [STAGES*CW-1:0] v);
        logic [TW-1:0] acc;
        acc = '0;
        for (int i = 0; i < STAGES; i++) acc = acc + TW'(v[i*CW +: CW]);
        return acc;
    endfunction

    AST_MIN_CLEARS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ext_min |-> (stage_sel[CW-1:0] == '0) && (stage_dly[CW-1:0] == '0)); // R4

    AST_MAX_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_min && ext_max) |-> (stage_sel[CW-1:0] == FULL_PAT) && (stage_dly[CW-1:0] == TOP_CNT)); // R5

    AST_MIN_BEATS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_min && ext_max) |-> (total_dly == '0)); // R6

    AST_CASC_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        casc_vec == ~casc_n_vec); // R7

    AST_NEXT_HELD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_vec[0] |-> (stage_sel[2*CW-1:CW] == '0)); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_hold && $past(latch_hold) && !ext_min && !ext_max
         && !$past(ext_min) && !$past(ext_max)) |-> $stable(stage_sel[CW-1:0])); // R3

    AST_TOTAL_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        total_dly == add_counts(stage_dly)); // R9

endmodule

bind dly_chain dly_chain_chk #(.ADDR_W(ADDR_W), .STAGES(STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_hold (latch_hold),
    .ext_min    (ext_min),
    .ext_max    (ext_max),
    .stage_sel  (stage_sel),
    .stage_dly  (stage_dly),
    .casc_vec   (casc_vec),
    .casc_n_vec (casc_n_vec),
    .total_dly  (total_dly)
);

// File: tb/dly_chain_tb.sv
`timescale 1ns/1ps
module dly_chain_tb;

    localparam int ADDR_W = 7;
    localparam int STAGES = 2;
    localparam int CW = ADDR_W + 1;
    localparam int TW = ADDR_W + 1 + $clog2(STAGES);

    typedef struct {
        logic [TW-1:0] tot;
        logic [CW-1:0] s0;
        logic [CW-1:0] s1;
        logic          c0;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic latch_hold = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [STAGES-2:0] casc_ctl = '0;
    logic ext_min = 1'b0;
    logic ext_max = 1'b0;
    logic [STAGES*CW-1:0] stage_sel;
    logic [STAGES*CW-1:0] stage_dly;
    logic [STAGES-1:0] casc_vec;
    logic [STAGES-1:0] casc_n_vec;
    logic [TW-1:0] total_dly;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    dly_chain #(.ADDR_W(ADDR_W), .STAGES(STAGES)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_hold (latch_hold),
        .addr       (addr),
        .casc_ctl   (casc_ctl),
        .ext_min    (ext_min),
        .ext_max    (ext_max),
        .stage_sel  (stage_sel),
        .stage_dly  (stage_dly),
        .casc_vec   (casc_vec),
        .casc_n_vec (casc_n_vec),
        .total_dly  (total_dly)
    );

    // driver: apply inputs, let n edges pass, queue the expected result
    task automatic step(input logic [ADDR_W-1:0] a, input logic c, input logic h,
                        input logic mn, input logic mx, input int n,
                        input logic [TW-1:0] et, input logic [CW-1:0] es0,
                        input logic [CW-1:0] es1, input logic ec, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; casc_ctl[0] = c; latch_hold = h; ext_min = mn; ext_max = mx;
        repeat (n) @(posedge clk);
        #2;
        e.tot = et; e.s0 = es0; e.s1 = es1; e.c0 = ec; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare queued items away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (total_dly !== e.tot || stage_sel[CW-1:0] !== e.s0 ||
                    stage_sel[2*CW-1:CW] !== e.s1 || casc_vec[0] !== e.c0 ||
                    casc_n_vec[0] !== ~e.c0) begin
                    failures++;
                    $display("FAIL %s: total=%0d sel0=%h sel1=%h casc=%b casc_n=%b expected total=%0d sel0=%h sel1=%h casc=%b casc_n=%b",
                             e.tag, total_dly, stage_sel[CW-1:0], stage_sel[2*CW-1:CW],
                             casc_vec[0], casc_n_vec[0], e.tot, e.s0, e.s1, e.c0, ~e.c0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 reset state, sampled while reset is still held
        step(7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1, 9'd0, 8'h00, 8'h00, 1'b0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R2, R7, R8: first stage follows the address, second held at minimum
        step(7'h05, 1'b0, 1'b0, 1'b0, 1'b0, 2, 9'd5, 8'h05, 8'h00, 1'b0, "R2 load 5");
        step(7'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 2, 9'd127, 8'h7F, 8'h00, 1'b0, "R2 load 127");
        // R8, R5, R7: cascade raised, first stage at maximum, second released
        step(7'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2, 9'd128, 8'hFC, 8'h00, 1'b1, "R8 cascade boundary");
        step(7'h33, 1'b1, 1'b0, 1'b0, 1'b0, 2, 9'd179, 8'hFC, 8'h33, 1'b1, "R8 second stage follows");
        // R3: held latches ignore address and cascade changes
        step(7'h10, 1'b0, 1'b1, 1'b0, 1'b0, 3, 9'd179, 8'hFC, 8'h33, 1'b1, "R3 hold");
        // R4: minimum override acts in the same cycle
        step(7'h10, 1'b0, 1'b1, 1'b1, 1'b0, 0, 9'd0, 8'h00, 8'h00, 1'b0, "R4 force min");
        // R10: released with latches closed, cleared pattern stays
        step(7'h10, 1'b0, 1'b1, 1'b0, 1'b0, 2, 9'd0, 8'h00, 8'h00, 1'b0, "R10 after min");
        // R6: both overrides, minimum wins
        step(7'h10, 1'b0, 1'b1, 1'b1, 1'b1, 0, 9'd0, 8'h00, 8'h00, 1'b0, "R6 min beats max");
        // R5: maximum override alone
        step(7'h10, 1'b0, 1'b1, 1'b0, 1'b1, 1, 9'd128, 8'hFC, 8'h00, 1'b1, "R5 force max");
        // R10: released with latches closed, written pattern 0x7C stays
        step(7'h10, 1'b0, 1'b1, 1'b0, 1'b0, 1, 9'd124, 8'h7C, 8'h00, 1'b0, "R10 after max");
        // R9: total tracks the combined code across the stage boundary
        for (int k = 0; k < STAGES * 128; k++) begin
            logic [CW-1:0] s0e;
            logic [CW-1:0] s1e;
            s0e = (k >= 128) ? 8'hFC : CW'(k);
            s1e = (k >= 128) ? CW'(k - 128) : 8'h00;
            step(ADDR_W'(k % 128), (k >= 128), 1'b0, 1'b0, 1'b0, 2, TW'(k), s0e, s1e,
                 (k >= 128), "R9 monotonic sweep");
        end
        @(posedge clk);
        #8;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule